// File: doc/BRIEF.md
# Four-Mode Addressable Sink Latch

This block keeps eight one-bit cells that each command one low-side sink switch. A single serial data bit and a 3-bit address reach the cells. Two active-low controls, a clear and an enable, set the mode. In latch mode the data bit is written into one cell at a time. In hold mode the switch pattern is frozen. In decode mode the address and data are routed straight to the outputs as a one-of-eight pattern. In clear mode every switch turns off and the cells are wiped.

The block is a clocked version of a transparent-latch part. The cells are flip-flops that load on the rising clock edge. The outputs are picked combinationally from the cells, from the decoder, or forced off, depending on the current mode. A host can use it as a working register that it fills one bit per cycle, or as a 3-to-8 demultiplexer for strobing loads. Address and data are used only while enable is low, so the address lines may move freely while enable is high.

Top module: `addr_sink_latch`

## Requirements
- R1: While `rst_n` is low, all eight cells are cleared. Once reset is released in hold mode, `sink_on` reads 8'h00 and `pin_lvl` reads 8'hFF.
- R2: Latch mode is `clr_n`=1 and `en_n`=0. At each rising clock edge in this mode, `din` is stored in the cell numbered `addr`. The new value appears on `sink_on[addr]` after that edge.
- R3: A latch-mode write leaves the other seven cells unchanged.
- R4: Hold mode is `clr_n`=1 and `en_n`=1. In this mode `sink_on` equals the stored cells, and it does not change across clock edges whatever `addr` and `din` do.
- R5: Decode mode is `clr_n`=0 and `en_n`=0. In this mode bit `addr` of `sink_on` equals `din` and every other bit is 0. The output follows the inputs in the same cycle.
- R6: Decode mode does not write the cells. When the block returns to hold mode, `sink_on` shows the contents stored before decode began.
- R7: Clear mode is `clr_n`=0 and `en_n`=1. In this mode `sink_on` is 8'h00 in the same cycle, for any `addr` and `din`. The cells are zeroed at the next rising edge, so a later return to hold mode reads 8'h00.
- R8: `pin_lvl` is the bitwise inverse of `sink_on` at all times. A 1 in `sink_on` means the switch is sinking, which gives a low pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the storage cells |
| rst_n | input | 1 | Asynchronous active-low reset of the cells |
| clr_n | input | 1 | Active-low clear control (mode select) |
| en_n | input | 1 | Active-low enable control (mode select) |
| addr | input | 3 | Cell / output select |
| din | input | 1 | Serial data bit |
| sink_on | output | 8 | Switch enables, 1 = sinking, bit i belongs to address i |
| pin_lvl | output | 8 | Pin-level view, inverse of `sink_on` |

## Verification
A cell stored wrongly, or a write that lands on the wrong address, stays hidden until the next time the block is in hold or latch mode. It then shows up on `sink_on` in the first cycle after the write edge. Each write in the sweep is therefore checked right away in hold mode against an arithmetic model of all eight cells. Decode and clear are combinational paths, and errors there appear in the same cycle. Damage they might do to the cells appears only on the return to hold mode, so each of those phases ends with a hold-mode comparison against the model.

// File: rtl/addr_sink_latch.sv
module addr_sink_latch #(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             en_n,
  input  logic [AW-1:0]    addr,
  input  logic             din,
  output logic [N_OUT-1:0] sink_on,
  output logic [N_OUT-1:0] pin_lvl
);

  logic [N_OUT-1:0] cells;
  logic [N_OUT-1:0] dec_vec;

  wire mode_latch  =  clr_n && !en_n;
  wire mode_decode = !clr_n && !en_n;
  wire mode_wipe   = !clr_n &&  en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cells <= '0;
    else if (mode_wipe)
      cells <= '0;
    else if (mode_latch)
      cells[addr] <= din;
  end

  always_comb begin
    dec_vec = '0;
    dec_vec[addr] = din;
  end

  assign sink_on = mode_decode ? dec_vec :
                   mode_wipe   ? '0      : cells;
  assign pin_lvl = ~sink_on;

endmodule

module addr_sink_latch_chk #(
  parameter int N_OUT = 8,
  localparam int AW = $clog2(N_OUT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             en_n,
  input logic [AW-1:0]    addr,
  input logic             din,
  input logic [N_OUT-1:0] sink_on,
  input logic [N_OUT-1:0] pin_lvl
);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_n && !en_n) && clr_n && en_n) |-> (sink_on[$past(addr)] == $past(din)));

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && en_n && $past(clr_n && en_n)) |-> $stable(sink_on));

  a_r5_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !en_n) |-> ($onehot0(sink_on) && (sink_on[addr] == din)));

  a_r7_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && en_n) |-> (sink_on == '0));

  a_r7_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr_n && en_n) && clr_n && en_n) |-> (sink_on == '0));

  a_r8_pins_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(sink_on) + $countones(pin_lvl)) == N_OUT) && ((sink_on & pin_lvl) == '0));

endmodule

bind addr_sink_latch addr_sink_latch_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
  .addr(addr), .din(din), .sink_on(sink_on), .pin_lvl(pin_lvl)
);

// File: tb/addr_sink_latch_test.sv
module addr_sink_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       en_n = 1'b1;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic [7:0] sink_on, pin_lvl;
  logic [7:0] model = '0;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_sink_latch uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
    .addr(addr), .din(din), .sink_on(sink_on), .pin_lvl(pin_lvl)
  );

  task automatic chk(input string req, input logic [7:0] e);
    vectors++;
    if (sink_on !== e || pin_lvl !== ~e) begin
      fails++;
      $display("FAIL %s: sink_on=%h pin_lvl=%h expected %h/%h", req, sink_on, pin_lvl, e, ~e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_bit(input logic [2:0] a, input logic d);
    clr_n = 1'b1; en_n = 1'b0; addr = a; din = d;
    step();
    en_n = 1'b1; addr = ~a; din = ~d;
    model[a] = d;
    #1 chk("R2/R3 write", model);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset", 8'h00);

    for (int i = 0; i < 8; i++) write_bit(3'(i), 1'(8'hA5 >> i));
    for (int i = 7; i >= 0; i--) write_bit(3'(i), 1'b1);
    for (int i = 0; i < 8; i += 3) write_bit(3'(i), 1'b0);

    clr_n = 1'b1; en_n = 1'b1;
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 2; d++) begin
        addr = 3'(a); din = 1'(d);
        step();
        #1 chk("R4 hold", model);
      end

    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 2; d++) begin
        clr_n = 1'b0; en_n = 1'b0; addr = 3'(a); din = 1'(d);
        #1 chk("R5 decode", 8'(d) << a);
        chk("R8 pins", 8'(d) << a);
        step();
      end
    clr_n = 1'b1; en_n = 1'b1;
    #1 chk("R6 decode keeps cells", model);
    step();
    chk("R6 decode keeps cells", model);

    for (int a = 0; a < 8; a++) begin
      clr_n = 1'b0; en_n = 1'b1; addr = 3'(a); din = 1'b1;
      #1 chk("R7 clear immediate", 8'h00);
      if (a == 0) begin
        clr_n = 1'b1;
        #1 chk("R7 before edge", model);
        clr_n = 1'b0;
      end
      step();
    end
    model = '0;
    clr_n = 1'b1; en_n = 1'b1;
    #1 chk("R7 cells wiped", model);

    write_bit(3'd6, 1'b1);
    write_bit(3'd1, 1'b1);
    clr_n = 1'b0; en_n = 1'b0; addr = 3'd3; din = 1'b1;
    #1 chk("R5 decode after writes", 8'h08);
    step();
    clr_n = 1'b1; en_n = 1'b1;
    #1 chk("R6 after decode", model);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule